// File: doc/BRIEF.md
# Page-Mode Pseudo-SRAM Sequencer

This block sits between a clocked request port and an asynchronous pseudo-SRAM that has a 16-bit data bus. It turns single reads, single writes and multi-word page reads into the chip-enable, output-enable, write-enable, byte-lane and sleep strobes the memory expects. Each access time is a parameter counted in clock cycles, so one netlist can serve several speed grades and clock rates.

After reset the sequencer keeps the memory deselected for a parameterised settling time. It then raises `init_done` and accepts requests through a ready/valid pair. A read burst runs through a page of `PAGE_WORDS` words. Only the low address bits step inside that page, and every word after the first waits the shorter in-page time. When a burst runs past the end of a page, the sequencer deselects the memory for one cycle and starts the next page with a full-latency access. Every finished word produces one `word_ack` pulse, and for a read `rd_data` carries the word in the same cycle.

A level request on `lp_req` puts the memory to sleep by driving its sleep pin low. When the request is removed, the sleep pin is released and the sequencer waits a recovery time before it accepts work again.

Top module: `psram_pager`

## Requirements
- R1: From reset until `init_done` rises, `mem_ce_n` stays high and `req_ready` stays low. `init_done` rises on the PWR_CYC-th clock edge after reset is released.
- R2: A read drives `mem_ce_n` and `mem_oe_n` low and keeps `mem_we_n` high. The first word is sampled T_ACC cycles after the accepting edge, and `word_ack` with `rd_data` is visible right after that edge.
- R3: A write drives `mem_ce_n` and `mem_we_n` low for T_WR cycles and keeps `mem_oe_n` high. The data bus is enabled only while `mem_we_n` is low, and the address and data hold steady while it is low.
- R4: Byte enable bit 0 selects the low byte lane (`mem_lb_n` low) and bit 1 selects the high byte lane (`mem_ub_n` low). A write changes only the selected bytes.
- R5: A read with `req_len` = N returns N+1 consecutive words. Inside one page, `mem_ce_n` and `mem_oe_n` stay low, only address bits [log2(PAGE_WORDS)-1:0] change, and each later word comes T_PAGE cycles after the one before it.
- R6: When a burst passes a page boundary, `mem_ce_n` goes high for one cycle and the next word takes 1+T_ACC cycles.
- R7: Exactly one `word_ack` pulse is produced for each completed word, and never without a preceding access.
- R8: With `lp_req` high while idle, `mem_zz_n` goes low on the next edge while `mem_ce_n` stays high and `req_ready` stays low.
- R9: After `lp_req` falls, `mem_zz_n` returns high on the next edge and `req_ready` returns T_REC+1 cycles after the fall, with `mem_ce_n` high throughout.
- R10: Before the data bus is enabled for a write, there is at least one cycle with `mem_oe_n` and `mem_ce_n` high and the bus released.
- R11: When `lp_req` and `req_valid` are both high in idle, the low-power request wins and no access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_be | input | 2 | Byte enables, bit 0 low byte |
| req_wdata | input | DW | Write data |
| req_len | input | LW | Read burst word count minus one |
| word_ack | output | 1 | One pulse per completed word |
| rd_data | output | DW | Read word, valid with `word_ack` |
| init_done | output | 1 | Power-up wait has elapsed |
| lp_req | input | 1 | Low-power request (level) |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte lane, active low |
| mem_ub_n | output | 1 | High byte lane, active low |
| mem_zz_n | output | 1 | Sleep control, active low |
| mem_dq_o | output | DW | Data toward memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | DW | Data from memory |

## Verification
The bench's memory model returns a poison word until the access time has passed since the last address or strobe change. It uses the in-page time only when the upper address bits are unchanged, so a controller that samples early, that treats a page-crossing word as in-page, or that skips the deselect cycle returns wrong data or acknowledges in the wrong cycle. A burst that starts three words before a page end and partial byte-lane writes read back through the pins expose a lane swap or a wrong boundary test. Requests issued during sleep, and read-to-write turnarounds, catch a controller that lets a request slip past the sleep request or drives the bus too early.

// File: rtl/psram_pager.sv
module psram_pager #(
  parameter int AW         = 22,
  parameter int DW         = 16,
  parameter int LW         = 5,
  parameter int PAGE_WORDS = 16,
  parameter int PWR_CYC    = 15000,
  parameter int T_ACC      = 7,
  parameter int T_PAGE     = 2,
  parameter int T_WR       = 7,
  parameter int T_REC      = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  input  logic [LW-1:0] req_len,
  output logic          word_ack,
  output logic [DW-1:0] rd_data,
  output logic          init_done,
  input  logic          lp_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic          mem_zz_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int PB   = $clog2(PAGE_WORDS);
  localparam int TM1  = (T_ACC > T_WR) ? T_ACC : T_WR;
  localparam int TM2  = (T_REC > T_PAGE) ? T_REC : T_PAGE;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(PWR_CYC + 1);

  typedef enum logic [2:0] {ST_PWR, ST_IDLE, ST_RD, ST_GAP, ST_WR, ST_LP, ST_REC} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pcnt;
  logic [LW-1:0] words_left;
  logic [1:0]    be_q;

  assign req_ready = (st == ST_IDLE) && !lp_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_PWR;
      pcnt       <= PW'(PWR_CYC - 1);
      cnt        <= '0;
      words_left <= '0;
      be_q       <= '0;
      init_done  <= 1'b0;
      word_ack   <= 1'b0;
      rd_data    <= '0;
      mem_addr   <= '0;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_zz_n   <= 1'b1;
      mem_dq_o   <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      word_ack <= 1'b0;
      case (st)
        ST_PWR:
          if (pcnt == '0) begin
            st        <= ST_IDLE;
            init_done <= 1'b1;
          end else pcnt <= pcnt - 1'b1;
        ST_IDLE:
          if (lp_req) begin
            st       <= ST_LP;
            mem_zz_n <= 1'b0;
          end else if (req_valid) begin
            mem_addr <= req_addr;
            be_q     <= req_be;
            mem_ce_n <= 1'b0;
            mem_lb_n <= ~req_be[0];
            mem_ub_n <= ~req_be[1];
            if (req_write) begin
              st        <= ST_WR;
              mem_we_n  <= 1'b0;
              mem_dq_o  <= req_wdata;
              mem_dq_oe <= 1'b1;
              cnt       <= CW'(T_WR - 1);
            end else begin
              st         <= ST_RD;
              mem_oe_n   <= 1'b0;
              words_left <= req_len;
              cnt        <= CW'(T_ACC - 1);
            end
          end
        ST_RD:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            rd_data  <= mem_dq_i;
            word_ack <= 1'b1;
            if (words_left == '0) begin
              st       <= ST_IDLE;
              mem_ce_n <= 1'b1;
              mem_oe_n <= 1'b1;
              mem_lb_n <= 1'b1;
              mem_ub_n <= 1'b1;
            end else begin
              words_left <= words_left - 1'b1;
              mem_addr   <= mem_addr + 1'b1;
              if (&mem_addr[PB-1:0]) begin
                st       <= ST_GAP;
                mem_ce_n <= 1'b1;
                mem_oe_n <= 1'b1;
                mem_lb_n <= 1'b1;
                mem_ub_n <= 1'b1;
              end else cnt <= CW'(T_PAGE - 1);
            end
          end
        ST_GAP: begin
          st       <= ST_RD;
          mem_ce_n <= 1'b0;
          mem_oe_n <= 1'b0;
          mem_lb_n <= ~be_q[0];
          mem_ub_n <= ~be_q[1];
          cnt      <= CW'(T_ACC - 1);
        end
        ST_WR:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            word_ack  <= 1'b1;
            st        <= ST_IDLE;
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
          end
        ST_LP:
          if (!lp_req) begin
            st       <= ST_REC;
            mem_zz_n <= 1'b1;
            cnt      <= CW'(T_REC - 1);
          end
        ST_REC:
          if (cnt == '0) st <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_ce_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (mem_ce_n && !req_ready));

  assert_rd_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  assert_wr_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  assert_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  assert_wr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_dq_o) && $stable(mem_addr)));

  assert_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr[AW-1:PB]));

  assert_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_ack |-> $past(!mem_ce_n));

  assert_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_zz_n |-> (mem_ce_n && !req_ready));

  assert_turn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n && mem_ce_n));

endmodule

// File: tb/test_psram_pager.sv
module test_psram_pager;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 22, DW = 16, LW = 5;
  localparam int PWR_CYC = 40, T_ACC = 7, T_PAGE = 2, T_WR = 6, T_REC = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, lp_req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_be = 2'b11;
  logic [DW-1:0] req_wdata = '0;
  logic [LW-1:0] req_len = '0;
  logic req_ready, word_ack, init_done;
  logic [DW-1:0] rd_data, mem_dq_o;
  logic [DW-1:0] mem_dq_i = 16'hBAD0;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_zz_n, mem_dq_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  psram_pager #(.AW(AW), .DW(DW), .LW(LW), .PAGE_WORDS(16), .PWR_CYC(PWR_CYC),
    .T_ACC(T_ACC), .T_PAGE(T_PAGE), .T_WR(T_WR), .T_REC(T_REC)) i_psram_pager (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_be,
    .req_wdata, .req_len, .word_ack, .rd_data, .init_done, .lp_req,
    .mem_addr, .mem_ce_n, .mem_oe_n, .mem_we_n, .mem_lb_n, .mem_ub_n,
    .mem_zz_n, .mem_dq_o, .mem_dq_oe, .mem_dq_i);

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input logic [AW-1:0] a);
    return a[15:0] ^ {a[21:16], 10'h2B5};
  endfunction

  // pin-level memory model
  logic [15:0] pin_mem [int];
  logic [15:0] exp_mem [int];
  bit was_act = 0, we_last = 1, ws_lb, ws_ub;
  int age = 0, need = T_ACC;
  logic [AW-1:0] last_a = '0, ws_a;
  logic [15:0] ws_d;

  always @(negedge clk) begin
    bit act;
    act = !mem_ce_n && !mem_oe_n;
    if (!act) age = 0;
    else if (!was_act || mem_addr != last_a) begin
      need = (was_act && mem_addr[AW-1:4] == last_a[AW-1:4]) ? T_PAGE : T_ACC;
      age = 1;
    end else age++;
    was_act = act;
    last_a = mem_addr;
    if (act && age >= need)
      mem_dq_i = pin_mem.exists(int'(mem_addr)) ? pin_mem[int'(mem_addr)] : pat(mem_addr);
    else mem_dq_i = 16'hBAD0;
    if (!mem_we_n && !mem_ce_n) begin
      ws_a = mem_addr;
      ws_d = mem_dq_oe ? mem_dq_o : 16'hBAD1;
      ws_lb = !mem_lb_n;
      ws_ub = !mem_ub_n;
    end
    if (!we_last && mem_we_n) begin
      logic [15:0] o;
      o = pin_mem.exists(int'(ws_a)) ? pin_mem[int'(ws_a)] : pat(ws_a);
      pin_mem[int'(ws_a)] = {ws_ub ? ws_d[15:8] : o[15:8], ws_lb ? ws_d[7:0] : o[7:0]};
    end
    we_last = mem_we_n;
  end

  // scoreboard: {kind, data, cycle}; kind 0 write, 1 first read, 2 in-page, 3 crossing
  typedef struct packed { logic [1:0] kind; logic [15:0] d; logic [31:0] c; } item_t;
  item_t q[$];

  function automatic string kname(input logic [1:0] k);
    case (k)
      2'd0: return "R3";
      2'd1: return "R2";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  bit prev_dq_oe = 0, prev_oe_n = 1, prev_ce_n = 1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (word_ack) begin
        if (q.size() == 0) check(0, "R7", "unexpected ack", 1, 0);
        else begin
          item_t it;
          it = q.pop_front();
          check(cyc == int'(it.c), kname(it.kind), "ack cycle", cyc, it.c);
          if (it.kind != 2'd0) check(rd_data == it.d, kname(it.kind), "read data", rd_data, it.d);
        end
      end
      if (!init_done && !mem_ce_n) check(0, "R1", "ce low before ready", 0, 1);
      if (mem_dq_oe && mem_we_n) check(0, "R3", "bus driven with we high", 1, 0);
      if (mem_dq_oe && !prev_dq_oe)
        check(prev_oe_n && prev_ce_n, "R10", "turnaround gap", {prev_oe_n, prev_ce_n}, 2'b11);
    end
    prev_dq_oe = mem_dq_oe;
    prev_oe_n = mem_oe_n;
    prev_ce_n = mem_ce_n;
  end

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [1:0] be,
                        input logic [15:0] wd, input int len);
    int t;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    req_len = LW'(len);
    while (!req_ready) @(negedge clk);
    t = cyc;
    if (wr) begin
      logic [15:0] o;
      o = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : pat(a);
      exp_mem[int'(a)] = {be[1] ? wd[15:8] : o[15:8], be[0] ? wd[7:0] : o[7:0]};
      q.push_back('{2'd0, 16'h0, 32'(t + 1 + T_WR)});
    end else begin
      for (int i = 0; i <= len; i++) begin
        logic [AW-1:0] ai;
        logic [1:0] k;
        ai = a + AW'(i);
        if (i == 0) begin t = t + 1 + T_ACC; k = 2'd1; end
        else if (ai[3:0] == 4'h0) begin t = t + 1 + T_ACC; k = 2'd3; end
        else begin t = t + T_PAGE; k = 2'd2; end
        q.push_back('{k, exp_mem.exists(int'(ai)) ? exp_mem[int'(ai)] : pat(ai), 32'(t)});
      end
    end
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic drain();
    while (q.size() != 0 || !req_ready) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(mem_ce_n == 1, "R1", "reset ce_n", mem_ce_n, 1);
    check(init_done == 0, "R1", "reset init_done", init_done, 0);
    check(req_ready == 0, "R1", "reset ready", req_ready, 0);
    check(mem_zz_n == 1 && mem_dq_oe == 0, "R8", "reset zz/oe", {mem_zz_n, mem_dq_oe}, 2'b10);
    rst_n = 1;
    n = 0;
    while (!init_done) begin @(negedge clk); n++; end
    check(n == PWR_CYC, "R1", "power-up wait", n, PWR_CYC);

    // R2 single reads
    do_req(0, 22'h000123, 2'b11, 0, 0);
    do_req(0, 22'h3ABCD7, 2'b11, 0, 0);
    // R3 / R4 writes and read back, then read right before write (R10)
    do_req(1, 22'h000040, 2'b11, 16'h1234, 0);
    do_req(0, 22'h000040, 2'b11, 0, 0);
    do_req(1, 22'h000041, 2'b01, 16'hAA55, 0);
    do_req(1, 22'h000042, 2'b10, 16'hC33C, 0);
    do_req(0, 22'h000041, 2'b11, 0, 1);
    do_req(1, 22'h000043, 2'b11, 16'h0F0F, 0);
    // R5 in-page burst
    do_req(0, 22'h100402, 2'b11, 0, 3);
    do_req(0, 22'h000040, 2'b11, 0, 3);
    // R6 page crossing burst
    do_req(0, 22'h02000D, 2'b11, 0, 5);
    do_req(0, 22'h00003E, 2'b11, 0, 4);
    drain();

    // R8 low power
    @(negedge clk);
    lp_req = 1;
    @(negedge clk);
    check(mem_zz_n == 0, "R8", "zz low", mem_zz_n, 0);
    check(req_ready == 0 && mem_ce_n == 1, "R8", "ready/ce in sleep", {req_ready, mem_ce_n}, 2'b01);
    // R11 request during sleep is not taken
    req_valid = 1; req_write = 0; req_addr = 22'h000777; req_len = '0;
    repeat (4) @(negedge clk);
    check(mem_ce_n == 1 && word_ack == 0, "R11", "access during sleep", {mem_ce_n, word_ack}, 2'b10);
    check(mem_zz_n == 0, "R11", "sleep held", mem_zz_n, 0);
    req_valid = 0;
    lp_req = 0;
    n = 0;
    @(negedge clk); n++;
    check(mem_zz_n == 1, "R9", "zz released", mem_zz_n, 1);
    while (!req_ready) begin
      if (!mem_ce_n) check(0, "R9", "ce during recovery", 0, 1);
      @(negedge clk); n++;
    end
    check(n == T_REC + 1, "R9", "recovery length", n, T_REC + 1);
    // R11 / R7: request still served after wake
    do_req(0, 22'h000777, 2'b11, 0, 0);
    do_req(1, 22'h00077F, 2'b11, 16'hBEEF, 0);
    do_req(0, 22'h00077E, 2'b11, 0, 2);
    drain();
    repeat (5) @(negedge clk);
    check(q.size() == 0, "R7", "pending acks", q.size(), 0);
    finish_run();
  end
endmodule